// File: doc/BRIEF.md
# Vector masked element write sequencer

This block runs one pass of an element-wise vector operation across a destination register group. A pass is launched by a one-cycle `start_i`. At that edge the block captures the start index, the active length, the mask-enable flag, the two agnostic policy bits, the signed group-multiplier code, the selected and destination element widths, the register byte count and the mask register. It then visits one element index per clock cycle.

Each body element, from the start index up to the active length minus one, takes one of three outcomes. It is handed to an external operation unit through a valid/index port. It is written with all-ones bytes through a byte-enabled fill port. Or it is left alone. When the tail-agnostic bit is set, the tail elements from the active length up to the end of the register group are then filled with all-ones bytes. The pass closes with a one-cycle done pulse. The start index is cleared once the body has been walked.

The element count that bounds the tail is derived from the signed group-multiplier code. This count is clamped so that a fractional group still covers its whole register.

Top module: `vec_mask_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `illegal_o`, `op_valid_o` and `fill_valid_o` are 0 and `vstart_o` is 0.
- R2: When the captured start index is greater than or equal to the captured active length, the cycle after `start_i` shows `done_o`=1 with no operation and no fill, and `vstart_o`=0.
- R3: Body indices run in ascending order, one per cycle, from the start index to the active length minus one. The first body index appears in the cycle after `start_i`.
- R4: The mask bit for element i is bit (i mod 64) of 64-bit word (i div 64) of `mask_i`, where word w occupies `mask_i[64w+63:64w]`. With `vm_i`=1 every body element is active, whatever its mask bit. An active body element raises `op_valid_o` with `elem_idx_o`=i and no fill.
- R5: A masked-off body element (`vm_i`=0 and mask bit 0) never raises `op_valid_o`. It raises `fill_valid_o` if `vma_i`=1 and raises nothing if `vma_i`=0.
- R6: With `vta_i`=1, each tail index from the active length up to the total element count minus one is filled, one per cycle, after the body. With `vta_i`=0, or when the active length is not below the total, the pass goes straight from the body to done.
- R7: The total element count is (`vlenb_i` << e) >> `esz_i`, where e = `esz_i` − `sew_i` + lmul, clamped to 0 when negative. `sew_i` and `esz_i` are log2 of the byte width (0..3 for 1, 2, 4 and 8 bytes).
- R8: `lmul_i` is read as a signed 3-bit value: 0..3 stand for ×1..×8 and 5..7 for ×1/8, ×1/4 and ×1/2. Code 4 is reserved. It gives a one-cycle `done_o` with `illegal_o`=1 in the cycle after `start_i`, makes no write, and keeps `vstart_o` at the start index.
- R9: A fill for element i with byte size n = 1 << `esz_q` and byte address b = i·n drives `fill_addr_o` = b with its low three bits cleared. It drives `fill_be_o` = ((1 << n) − 1) << (b mod 8).
- R10: `vstart_o` holds the captured start index while the body is walked and reads 0 in every later cycle of a legal pass.
- R11: `done_o` lasts one cycle and is followed by idle. `busy_o` is high from the cycle after `start_i` through the done cycle. `start_i` and all configuration inputs are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a pass (sampled only while idle) |
| vstart_i | input | IDX_W | First body index |
| vl_i | input | IDX_W | Active length |
| vm_i | input | 1 | 1 = unmasked, 0 = use mask bits |
| vma_i | input | 1 | Mask-agnostic policy: fill masked-off elements |
| vta_i | input | 1 | Tail-agnostic policy: fill tail elements |
| lmul_i | input | 3 | Signed group multiplier code |
| sew_i | input | 2 | log2 of selected element bytes |
| esz_i | input | 2 | log2 of destination element bytes |
| vlenb_i | input | VLENB_W | Bytes per vector register |
| mask_i | input | MASK_BITS | Mask register contents |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| illegal_o | output | 1 | Reserved multiplier code, valid with done |
| vstart_o | output | IDX_W | Start index register |
| elem_idx_o | output | IDX_W | Current element index |
| op_valid_o | output | 1 | Forward element to the operation unit |
| fill_valid_o | output | 1 | All-ones write this cycle |
| fill_addr_o | output | ADDR_W | 8-byte-aligned byte address of the write |
| fill_be_o | output | 8 | Byte enables within the 8-byte beat |

## Verification
Every output comes straight from registers that change at the edge where `start_i` is seen, so the first element decision is due one cycle after the start pulse. Each later element, the tail entries and the done pulse follow one per cycle. Even an early exit or a reserved code produces its done pulse in that first cycle. The bench drives at the falling edge and compares a full expected output tuple at every following falling edge, indexing the expected sequence by cycle count from the start. It also confirms idle one cycle after done.

// File: rtl/vms_pkg.sv
package vms_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_TAIL, ST_DONE} vms_state_e;

  localparam logic [2:0] LMUL_RSVD = 3'b100;

  function automatic logic [7:0] elem_be(input logic [1:0] esz, input logic [2:0] ofs);
    logic [7:0] base;
    case (esz)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0f;
      default: base = 8'hff;
    endcase
    return base << ofs;
  endfunction
endpackage

// File: rtl/vms_total.sv
module vms_total #(
  parameter int VLENB_W = 6,
  parameter int IDX_W   = 9
) (
  input  logic [VLENB_W-1:0] vlenb_i,
  input  logic [2:0]         lmul_i,
  input  logic [1:0]         sew_i,
  input  logic [1:0]         esz_i,
  output logic [IDX_W-1:0]   tot_o,
  output logic               rsvd_o
);
  localparam int SW = VLENB_W + 6;

  logic signed [4:0] emul_s;
  logic [2:0]        sh;
  logic [SW-1:0]     scaled;

  always_comb begin
    emul_s = $signed({3'b000, esz_i}) - $signed({3'b000, sew_i})
           + $signed({{2{lmul_i[2]}}, lmul_i});
    // negative group exponent is clamped: fractional groups span one register
    sh     = emul_s[4] ? 3'd0 : emul_s[2:0];
    scaled = {{(SW-VLENB_W){1'b0}}, vlenb_i} << sh;
    tot_o  = IDX_W'(scaled >> esz_i);
    rsvd_o = (lmul_i == vms_pkg::LMUL_RSVD);
  end
endmodule

// File: rtl/vms_mask_pick.sv
module vms_mask_pick #(
  parameter int MASK_BITS = 256,
  parameter int IDX_W     = 9
) (
  input  logic [MASK_BITS-1:0] mask_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic                 bit_o
);
  localparam int NW     = MASK_BITS / 64;
  localparam int WSEL_W = IDX_W - 6;
  localparam int NW_PAD = 1 << WSEL_W;

  logic [63:0] words [NW_PAD];

  for (genvar w = 0; w < NW_PAD; w++) begin : g_word
    if (w < NW) begin : g_live
      assign words[w] = mask_i[w*64 +: 64];
    end else begin : g_pad
      assign words[w] = '0;
    end
  end

  assign bit_o = words[idx_i[IDX_W-1:6]][idx_i[5:0]];
endmodule

// File: rtl/vms_fill_enc.sv
module vms_fill_enc #(
  parameter int IDX_W  = 9,
  parameter int ADDR_W = 12
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        esz_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        be_o
);
  logic [ADDR_W-1:0] byte_addr;

  always_comb begin
    byte_addr = {{(ADDR_W-IDX_W){1'b0}}, idx_i} << esz_i;
    addr_o    = {byte_addr[ADDR_W-1:3], 3'b000};
    be_o      = vms_pkg::elem_be(esz_i, byte_addr[2:0]);
  end
endmodule

// File: rtl/vms_ctrl.sv
module vms_ctrl #(
  parameter int IDX_W     = 9,
  parameter int MASK_BITS = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [IDX_W-1:0]      vstart_i,
  input  logic [IDX_W-1:0]      vl_i,
  input  logic                  vm_i,
  input  logic                  vma_i,
  input  logic                  vta_i,
  input  logic [1:0]            esz_i,
  input  logic [MASK_BITS-1:0]  mask_i,
  input  logic [IDX_W-1:0]      tot_i,
  input  logic                  rsvd_i,
  output vms_pkg::vms_state_e   st_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [IDX_W-1:0]      vl_o,
  output logic                  vm_o,
  output logic                  vma_o,
  output logic [1:0]            esz_o,
  output logic [MASK_BITS-1:0]  mask_o,
  output logic                  ill_o,
  output logic [IDX_W-1:0]      vstart_o
);
  import vms_pkg::*;

  vms_state_e         st_q;
  logic [IDX_W-1:0]   idx_q, vl_q, tot_q, vstart_q;
  logic               vm_q, vma_q, vta_q, ill_q;
  logic [1:0]         esz_q;
  logic [MASK_BITS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      vl_q     <= '0;
      tot_q    <= '0;
      vstart_q <= '0;
      vm_q     <= 1'b0;
      vma_q    <= 1'b0;
      vta_q    <= 1'b0;
      ill_q    <= 1'b0;
      esz_q    <= '0;
      mask_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          vl_q     <= vl_i;
          tot_q    <= tot_i;
          vm_q     <= vm_i;
          vma_q    <= vma_i;
          vta_q    <= vta_i;
          esz_q    <= esz_i;
          mask_q   <= mask_i;
          idx_q    <= vstart_i;
          ill_q    <= rsvd_i;
          if (rsvd_i) begin
            vstart_q <= vstart_i;
            st_q     <= ST_DONE;
          end else if (vstart_i >= vl_i) begin
            vstart_q <= '0;
            st_q     <= ST_DONE;
          end else begin
            vstart_q <= vstart_i;
            st_q     <= ST_BODY;
          end
        end
        ST_BODY: begin
          if (idx_q == vl_q - 1'b1) begin
            vstart_q <= '0;
            if (vta_q && (vl_q < tot_q)) begin
              idx_q <= vl_q;
              st_q  <= ST_TAIL;
            end else begin
              st_q  <= ST_DONE;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (idx_q == tot_q - 1'b1) st_q <= ST_DONE;
          else                       idx_q <= idx_q + 1'b1;
        end
        default: begin
          st_q  <= ST_IDLE;
          ill_q <= 1'b0;
        end
      endcase
    end
  end

  assign st_o     = st_q;
  assign idx_o    = idx_q;
  assign vl_o     = vl_q;
  assign vm_o     = vm_q;
  assign vma_o    = vma_q;
  assign esz_o    = esz_q;
  assign mask_o   = mask_q;
  assign ill_o    = ill_q;
  assign vstart_o = vstart_q;

  // R3: consecutive body cycles advance the index by exactly one
  a_r3_body_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BODY && $past(st_q) == ST_BODY) |-> idx_q == IDX_W'($past(idx_q) + 1'b1));
  // R6: tail indices stay within [vl, total)
  a_r6_tail_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL) |-> (idx_q >= vl_q && idx_q < tot_q));
  // R10: start index is cleared once the body is done
  a_r10_vstart_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL) |-> vstart_q == '0);
  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE) |=> st_q == ST_IDLE);
endmodule

// File: rtl/vec_mask_seq.sv
module vec_mask_seq #(
  parameter int VLENB_MAX = 32,
  localparam int VLENB_W   = $clog2(VLENB_MAX) + 1,
  localparam int MASK_BITS = VLENB_MAX * 8,
  localparam int IDX_W     = $clog2(MASK_BITS) + 1,
  localparam int ADDR_W    = IDX_W + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     vstart_i,
  input  logic [IDX_W-1:0]     vl_i,
  input  logic                 vm_i,
  input  logic                 vma_i,
  input  logic                 vta_i,
  input  logic [2:0]           lmul_i,
  input  logic [1:0]           sew_i,
  input  logic [1:0]           esz_i,
  input  logic [VLENB_W-1:0]   vlenb_i,
  input  logic [MASK_BITS-1:0] mask_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 illegal_o,
  output logic [IDX_W-1:0]     vstart_o,
  output logic [IDX_W-1:0]     elem_idx_o,
  output logic                 op_valid_o,
  output logic                 fill_valid_o,
  output logic [ADDR_W-1:0]    fill_addr_o,
  output logic [7:0]           fill_be_o
);
  import vms_pkg::*;

  logic [IDX_W-1:0]     tot;
  logic                 rsvd;
  vms_state_e           st;
  logic [IDX_W-1:0]     idx, vl_q;
  logic                 vm_q, vma_q, ill_q, mbit, live;
  logic [1:0]           esz_q;
  logic [MASK_BITS-1:0] mask_q;
  logic                 in_body, in_tail;

  vms_total #(.VLENB_W(VLENB_W), .IDX_W(IDX_W)) u_total (
    .vlenb_i (vlenb_i),
    .lmul_i  (lmul_i),
    .sew_i   (sew_i),
    .esz_i   (esz_i),
    .tot_o   (tot),
    .rsvd_o  (rsvd)
  );

  vms_ctrl #(.IDX_W(IDX_W), .MASK_BITS(MASK_BITS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vstart_i (vstart_i),
    .vl_i     (vl_i),
    .vm_i     (vm_i),
    .vma_i    (vma_i),
    .vta_i    (vta_i),
    .esz_i    (esz_i),
    .mask_i   (mask_i),
    .tot_i    (tot),
    .rsvd_i   (rsvd),
    .st_o     (st),
    .idx_o    (idx),
    .vl_o     (vl_q),
    .vm_o     (vm_q),
    .vma_o    (vma_q),
    .esz_o    (esz_q),
    .mask_o   (mask_q),
    .ill_o    (ill_q),
    .vstart_o (vstart_o)
  );

  vms_mask_pick #(.MASK_BITS(MASK_BITS), .IDX_W(IDX_W)) u_mask (
    .mask_i (mask_q),
    .idx_i  (idx),
    .bit_o  (mbit)
  );

  vms_fill_enc #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fill (
    .idx_i  (idx),
    .esz_i  (esz_q),
    .addr_o (fill_addr_o),
    .be_o   (fill_be_o)
  );

  assign in_body      = (st == ST_BODY);
  assign in_tail      = (st == ST_TAIL);
  assign live         = vm_q | mbit;
  assign busy_o       = (st != ST_IDLE);
  assign done_o       = (st == ST_DONE);
  assign illegal_o    = done_o & ill_q;
  assign elem_idx_o   = (in_body | in_tail) ? idx : '0;
  assign op_valid_o   = in_body & live;
  assign fill_valid_o = (in_body & ~live & vma_q) | in_tail;

  // R5: one element gets either the result or a fill, never both
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> !fill_valid_o);
  // R4: forwarded elements lie inside the body
  a_r4_op_in_body: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> elem_idx_o < vl_q);
  // R8: an illegal pass ends without writes
  a_r8_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && !op_valid_o && !fill_valid_o));
  // R9: every fill enables at least one byte
  a_r9_be_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> fill_be_o != 8'h00);
  // R2: the done cycle carries no element traffic
  a_r2_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!op_valid_o && !fill_valid_o));
endmodule

// File: tb/vec_mask_seq_test.sv
module vec_mask_seq_test;
  localparam int VLENB_MAX = 32;
  localparam int VLENB_W   = $clog2(VLENB_MAX) + 1;
  localparam int MASK_BITS = VLENB_MAX * 8;
  localparam int IDX_W     = $clog2(MASK_BITS) + 1;
  localparam int ADDR_W    = IDX_W + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [IDX_W-1:0] vstart_i = '0, vl_i = '0;
  logic vm_i = 1'b0, vma_i = 1'b0, vta_i = 1'b0;
  logic [2:0] lmul_i = '0;
  logic [1:0] sew_i = '0, esz_i = '0;
  logic [VLENB_W-1:0] vlenb_i = '0;
  logic [MASK_BITS-1:0] mask_i = '0;
  logic busy_o, done_o, illegal_o, op_valid_o, fill_valid_o;
  logic [IDX_W-1:0] vstart_o, elem_idx_o;
  logic [ADDR_W-1:0] fill_addr_o;
  logic [7:0] fill_be_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  vec_mask_seq #(.VLENB_MAX(VLENB_MAX)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .vstart_i(vstart_i), .vl_i(vl_i),
    .vm_i(vm_i), .vma_i(vma_i), .vta_i(vta_i), .lmul_i(lmul_i), .sew_i(sew_i),
    .esz_i(esz_i), .vlenb_i(vlenb_i), .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o),
    .illegal_o(illegal_o), .vstart_o(vstart_o), .elem_idx_o(elem_idx_o),
    .op_valid_o(op_valid_o), .fill_valid_o(fill_valid_o), .fill_addr_o(fill_addr_o),
    .fill_be_o(fill_be_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual still running, expected pass end");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // R7: total element count with clamped group exponent
  function automatic int tot_model(int vlenb, int lmul, int sew, int esz);
    int e;
    e = esz - sew + ((lmul >= 4) ? lmul - 8 : lmul);
    if (e < 0) e = 0;
    return (vlenb * (1 << e)) / (1 << esz);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(logic b, logic d, logic il, logic op, logic fl,
      logic [IDX_W-1:0] vs, logic [IDX_W-1:0] ix, logic [ADDR_W-1:0] ad, logic [7:0] be);
    return {28'd0, b, d, il, op, fl, vs, ix, ad, be};
  endfunction

  task automatic run_pass(input int vs, input int vl, input bit vm, input bit ma, input bit ta,
      input int lmul, input int sew, input int esz, input int vlenb,
      input logic [MASK_BITS-1:0] msk, input bit disturb);
    int tot, nb, nt, ncyc;
    bit ill;
    @(negedge clk);
    vstart_i = IDX_W'(vs); vl_i = IDX_W'(vl); vm_i = vm; vma_i = ma; vta_i = ta;
    lmul_i = 3'(lmul); sew_i = 2'(sew); esz_i = 2'(esz); vlenb_i = VLENB_W'(vlenb);
    mask_i = msk; start_i = 1'b1;
    ill  = (lmul == 4);
    tot  = tot_model(vlenb, lmul, sew, esz);
    nb   = (!ill && vs < vl) ? vl - vs : 0;
    nt   = (nb > 0 && ta && vl < tot) ? tot - vl : 0;
    ncyc = nb + nt + 1;
    for (int c = 0; c < ncyc; c++) begin
      int ix, nbytes, baddr;
      bit ib, it, dn, mb, eop, efl;
      logic [IDX_W-1:0] evs, eix;
      logic [ADDR_W-1:0] ead;
      logic [7:0] ebe;
      string tag;
      @(negedge clk);
      if (disturb && c != ncyc - 1) begin
        // R11: inputs and start are ignored while busy
        start_i = 1'b1;
        vstart_i = IDX_W'($urandom); vl_i = IDX_W'($urandom); vm_i = 1'($urandom);
        vma_i = 1'($urandom); vta_i = 1'($urandom); lmul_i = 3'($urandom);
        esz_i = 2'($urandom); sew_i = 2'($urandom); vlenb_i = VLENB_W'($urandom);
        mask_i = ~mask_i;
      end else begin
        start_i = 1'b0;
      end
      ib = (c < nb);
      it = (c >= nb && c < nb + nt);
      dn = (c == ncyc - 1);
      ix = ib ? vs + c : vl + (c - nb);
      // R4: element i reads bit i%64 of 64-bit word i/64
      mb = vm || (ib && msk[(ix / 64) * 64 + (ix % 64)]);
      eop = ib && mb;
      efl = (ib && !mb && ma) || it;
      evs = (ill || ib) ? IDX_W'(vs) : '0;  // R10
      eix = (eop || efl) ? IDX_W'(ix) : elem_idx_o;
      nbytes = 1 << esz;  // R9
      baddr  = ix * nbytes;
      ead = efl ? ADDR_W'(baddr - (baddr % 8)) : fill_addr_o;
      ebe = efl ? 8'(((1 << nbytes) - 1) << (baddr % 8)) : fill_be_o;
      if (ill) tag = "R8";
      else if (nb == 0) tag = "R2";
      else if (it) tag = "R6/R7/R9";
      else if (ib && !mb) tag = "R5/R9";
      else if (ib) tag = "R3/R4/R10";
      else tag = "R11";
      if (disturb) tag = {tag, "/R11"};
      check(tag,
        pack(busy_o, done_o, illegal_o, op_valid_o, fill_valid_o, vstart_o, elem_idx_o, fill_addr_o, fill_be_o),
        pack(1'b1, dn, dn && ill, eop, efl, evs, eix, ead, ebe));
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R11 idle after done", {60'd0, busy_o, done_o, op_valid_o, fill_valid_o}, 64'd0);
  endtask

  function automatic logic [MASK_BITS-1:0] rnd_mask();
    logic [MASK_BITS-1:0] m;
    for (int w = 0; w < MASK_BITS / 32; w++) m[w*32 +: 32] = $urandom;
    return m;
  endfunction

  initial begin
    logic [MASK_BITS-1:0] m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {44'd0, busy_o, done_o, illegal_o, op_valid_o, fill_valid_o, 6'd0, vstart_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", {44'd0, busy_o, done_o, illegal_o, op_valid_o, fill_valid_o, 6'd0, vstart_o}, 64'd0);

    m = rnd_mask();
    run_pass(3, 10, 1'b0, 1'b1, 1'b1, 4, 0, 0, 16, m, 1'b0);   // R8 reserved code
    run_pass(5, 5, 1'b0, 1'b1, 1'b1, 0, 0, 0, 16, m, 1'b0);    // R2 equal
    run_pass(9, 4, 1'b1, 1'b1, 1'b1, 0, 0, 0, 16, m, 1'b0);    // R2 beyond
    run_pass(0, 0, 1'b1, 1'b1, 1'b1, 0, 0, 0, 16, m, 1'b0);    // R2 empty
    run_pass(0, 12, 1'b1, 1'b0, 1'b1, 0, 0, 0, 16, '0, 1'b0);  // R4 unmasked ignores zero mask
    run_pass(0, 200, 1'b0, 1'b1, 1'b1, 3, 0, 0, 32, m, 1'b0);  // R4 mask words above 64
    run_pass(2, 14, 1'b0, 1'b0, 1'b1, 0, 0, 0, 16, m, 1'b0);   // R5 undisturbed masked-off
    run_pass(1, 3, 1'b1, 1'b1, 1'b0, 0, 0, 0, 16, m, 1'b0);    // R6 tail left alone
    run_pass(0, 4, 1'b0, 1'b1, 1'b1, 5, 0, 0, 16, m, 1'b0);    // R7 fractional clamps to register
    run_pass(0, 5, 1'b0, 1'b1, 1'b1, 0, 0, 1, 16, m, 1'b0);    // R7 widened destination
    run_pass(1, 3, 1'b0, 1'b1, 1'b1, 7, 0, 3, 16, m, 1'b0);    // R7/R9 8-byte elements
    run_pass(2, 7, 1'b0, 1'b1, 1'b1, 1, 2, 2, 8, m, 1'b0);     // R9 4-byte lanes
    run_pass(1, 9, 1'b0, 1'b1, 1'b1, 0, 0, 0, 16, m, 1'b1);    // R11 disturbed pass

    for (int k = 0; k < 250; k++) begin
      int lmul, sew, esz, vlenb, tot, vl, vs;
      lmul  = ($urandom % 10 == 0) ? 4 : (($urandom % 2) ? int'($urandom % 4) : 5 + int'($urandom % 3));
      sew   = $urandom % 4;
      esz   = ($urandom % 2) ? sew : int'($urandom % 4);
      vlenb = 8 << ($urandom % 3);
      tot   = tot_model(vlenb, lmul, sew, esz);
      vl    = $urandom % (tot + 1);
      vs    = ($urandom % 4 == 0) ? int'($urandom % (vl + 3)) : int'($urandom % (vl / 2 + 1));
      run_pass(vs, vl, 1'($urandom), 1'($urandom), 1'($urandom), lmul, sew, esz, vlenb,
               rnd_mask(), ($urandom % 8) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule